// File: doc/BRIEF.md
# Serial Packet Receive Filter

This block sits between a bit-level demodulator and a receive FIFO. It watches the incoming serial bit stream for a programmable synchronisation word. Every bit before that word, including any preamble, is dropped. Once the word is found, the block assembles bytes MSB first and walks the packet header. The header holds an optional length byte and an optional node-address byte. Only the payload bytes that follow are handed to the FIFO, one write strobe per byte.

The address byte is filtered in one of three modes. The node address can be accepted alone, together with the broadcast value 0x00, or together with both 0x00 and 0xFF. A rejected address abandons the packet, and the block goes back to hunting for the synchronisation word. A 16-bit CRC covers the length, address and payload bytes. It is compared with the two CRC bytes that close the packet. A good packet raises a pass pulse and a bad one raises an error pulse. In discard mode a bad packet also raises a drop pulse, which tells the FIFO to rewind its write pointer to where the packet began. A single event output can report either synchronisation-word detection or address acceptance.

Top module: `pkt_rx_filter`

## Requirements
- R1: After reset every output is 0. `sync_det` pulses for one cycle, in the cycle after the clock edge that takes in the last bit of the `cfg_sync` pattern. This happens only while the block is hunting, not inside a packet.
- R2: The synchronisation word, the bits before it, the length byte, the address byte and the two CRC bytes never cause a write. Only payload bytes raise `wr_stb`.
- R3: Bits are packed MSB first. `wr_data` carries payload bytes in arrival order, and each is valid in the cycle that `wr_stb` is high. Cycles where `bit_valid` is low take in no bit.
- R4: With `cfg_len_en`=1, the first byte after the synchronisation word is the payload length. If it is larger than `cfg_max_len`, the packet is abandoned with no writes and no result pulse. With `cfg_len_en`=0, every packet carries exactly `cfg_max_len` payload bytes. A payload length of 0 is legal.
- R5: With `cfg_addr_en`=1, the next header byte is the address. With `cfg_addr_mode`=0, only a value equal to `cfg_node_addr` is accepted.
- R6: With `cfg_addr_mode`=1, the value 0x00 is also accepted.
- R7: With `cfg_addr_mode`=2 or 3, both 0x00 and 0xFF are also accepted.
- R8: A rejected address gives no write, no `addr_match` and no result pulse, and the block resumes hunting. An accepted address pulses `addr_match` once.
- R9: The CRC uses polynomial 0x1021 with initial value 0xFFFF and no final inversion. It is fed MSB first over the length, address and payload bytes. The received CRC is high byte then low byte. On a match, `pkt_ok` pulses once after the last CRC bit.
- R10: On a CRC mismatch, `pkt_bad` pulses instead. `pkt_drop` pulses in the same cycle only when `cfg_crc_drop`=1.
- R11: `evt_pulse` follows `sync_det` when `cfg_evt_addr`=0 and follows `addr_match` when `cfg_evt_addr`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | A demodulated bit is present this cycle |
| bit_in | input | 1 | Demodulated bit |
| cfg_sync | input | SYNC_W | Synchronisation word, first bit in the MSB |
| cfg_len_en | input | 1 | Packet carries a length byte |
| cfg_addr_en | input | 1 | Packet carries an address byte |
| cfg_addr_mode | input | 2 | 0 node only, 1 adds 0x00, 2/3 add 0x00 and 0xFF |
| cfg_node_addr | input | 8 | Node address |
| cfg_max_len | input | 8 | Length limit, or fixed length when no length byte |
| cfg_crc_drop | input | 1 | Raise drop on CRC error |
| cfg_evt_addr | input | 1 | Event source: 0 sync detect, 1 address accept |
| wr_stb | output | 1 | Payload byte write strobe |
| wr_data | output | 8 | Payload byte |
| sync_det | output | 1 | Synchronisation word found |
| addr_match | output | 1 | Address accepted |
| evt_pulse | output | 1 | Selected event |
| pkt_ok | output | 1 | Packet complete, CRC good |
| pkt_bad | output | 1 | Packet complete, CRC bad |
| pkt_drop | output | 1 | Rewind FIFO to packet start |

## Verification
The assertions assume that the configuration inputs stay constant while a packet is in flight. They also assume that the bits leading into a synchronisation word do not already hold that word. The bench changes configuration only during idle gaps between packets. Each packet opens with an alternating preamble, followed by a synchronisation word that cannot be formed from a shifted copy of that preamble. The bench sweeps every address mode against node, broadcast and foreign address values, with and without a length byte. It also inserts gaps in `bit_valid` so that bit acceptance is checked separately from the clock.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_HUNT, ST_LEN, ST_ADDR, ST_BODY, ST_CRCH, ST_CRCL
  } rx_state_t;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      if (r[CRC_W-1] ^ d[i]) r = (r << 1) ^ CRC_POLY;
      else                   r = r << 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/prx_sync_hunt.sv
module prx_sync_hunt #(
  parameter int SYNC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              hunting,
  input  logic [SYNC_W-1:0] pattern,
  output logic              hit
);
  localparam int HIST_W = SYNC_W - 1;

  logic [HIST_W-1:0] hist_q, hist_n;

  always_comb begin
    hist_n = hist_q;
    if (bit_valid) hist_n = {hist_q[HIST_W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_n;
  end

  assign hit = hunting && bit_valid && ({hist_q, bit_in} == pattern);
endmodule

// File: rtl/prx_byte_asm.sv
module prx_byte_asm
  import pkt_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              restart,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-2:0] sh_q, sh_n;

  always_comb begin
    cnt_n = cnt_q;
    sh_n  = sh_q;
    if (restart) begin
      cnt_n = '0;
    end else if (bit_valid) begin
      cnt_n = cnt_q + 1'b1;
      sh_n  = {sh_q[BYTE_W-3:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
    end
  end

  assign byte_stb  = bit_valid && !restart && (cnt_q == CNT_W'(BYTE_W - 1));
  assign byte_data = {sh_q, bit_in};
endmodule

// File: rtl/prx_crc16.sv
module prx_crc16
  import pkt_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              upd,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_q
);
  logic [CRC_W-1:0] crc_n;

  always_comb begin
    crc_n = crc_q;
    if (init)     crc_n = CRC_SEED;
    else if (upd) crc_n = crc_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_n;
  end
endmodule

// File: rtl/pkt_rx_filter.sv
module pkt_rx_filter
  import pkt_rx_pkg::*;
#(
  parameter int SYNC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic [SYNC_W-1:0] cfg_sync,
  input  logic              cfg_len_en,
  input  logic              cfg_addr_en,
  input  logic [1:0]        cfg_addr_mode,
  input  logic [7:0]        cfg_node_addr,
  input  logic [7:0]        cfg_max_len,
  input  logic              cfg_crc_drop,
  input  logic              cfg_evt_addr,
  output logic              wr_stb,
  output logic [7:0]        wr_data,
  output logic              sync_det,
  output logic              addr_match,
  output logic              evt_pulse,
  output logic              pkt_ok,
  output logic              pkt_bad,
  output logic              pkt_drop
);
  localparam logic [BYTE_W-1:0] BCAST_LO = '0;
  localparam logic [BYTE_W-1:0] BCAST_HI = '1;

  rx_state_t         state_q, state_n;
  logic [BYTE_W-1:0] remain_q, remain_n;
  logic [BYTE_W-1:0] crch_q, crch_n;
  logic              hunting, hit, restart;
  logic              byte_stb;
  logic [BYTE_W-1:0] byte_data;
  logic              crc_upd;
  logic [CRC_W-1:0]  crc_val;
  logic              addr_ok;

  logic              wr_n, sync_n, amatch_n, ok_n, bad_n, drop_n;
  logic [BYTE_W-1:0] wdata_n;

  assign hunting = (state_q == ST_HUNT);
  assign restart = hit;

  prx_sync_hunt #(.SYNC_W(SYNC_W)) u_hunt (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .hunting(hunting), .pattern(cfg_sync), .hit(hit)
  );

  prx_byte_asm u_asm (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .restart(restart), .byte_stb(byte_stb), .byte_data(byte_data)
  );

  assign crc_upd = byte_stb &&
                   (state_q == ST_LEN || state_q == ST_ADDR || state_q == ST_BODY);

  prx_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .init(restart), .upd(crc_upd),
    .din(byte_data), .crc_q(crc_val)
  );

  // Address filter: node always, 0x00 for modes 1..3, 0xFF for modes 2..3
  always_comb begin
    addr_ok = (byte_data == cfg_node_addr);
    if (cfg_addr_mode != 2'd0 && byte_data == BCAST_LO) addr_ok = 1'b1;
    if (cfg_addr_mode[1]      && byte_data == BCAST_HI) addr_ok = 1'b1;
  end

  always_comb begin
    state_n  = state_q;
    remain_n = remain_q;
    crch_n   = crch_q;
    wr_n     = 1'b0;
    wdata_n  = wr_data;
    sync_n   = 1'b0;
    amatch_n = 1'b0;
    ok_n     = 1'b0;
    bad_n    = 1'b0;
    drop_n   = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        if (hit) begin
          sync_n   = 1'b1;
          remain_n = cfg_max_len;
          if (cfg_len_en)             state_n = ST_LEN;
          else if (cfg_addr_en)       state_n = ST_ADDR;
          else if (cfg_max_len == '0) state_n = ST_CRCH;
          else                        state_n = ST_BODY;
        end
      end
      ST_LEN: begin
        if (byte_stb) begin
          remain_n = byte_data;
          if (byte_data > cfg_max_len) state_n = ST_HUNT;
          else if (cfg_addr_en)        state_n = ST_ADDR;
          else if (byte_data == '0)    state_n = ST_CRCH;
          else                         state_n = ST_BODY;
        end
      end
      ST_ADDR: begin
        if (byte_stb) begin
          if (!addr_ok)              state_n = ST_HUNT;
          else begin
            amatch_n = 1'b1;
            state_n  = (remain_q == '0) ? ST_CRCH : ST_BODY;
          end
        end
      end
      ST_BODY: begin
        if (byte_stb) begin
          wr_n     = 1'b1;
          wdata_n  = byte_data;
          remain_n = remain_q - 1'b1;
          if (remain_q == BYTE_W'(1)) state_n = ST_CRCH;
        end
      end
      ST_CRCH: begin
        if (byte_stb) begin
          crch_n  = byte_data;
          state_n = ST_CRCL;
        end
      end
      ST_CRCL: begin
        if (byte_stb) begin
          state_n = ST_HUNT;
          if ({crch_q, byte_data} == crc_val) ok_n = 1'b1;
          else begin
            bad_n  = 1'b1;
            drop_n = cfg_crc_drop;
          end
        end
      end
      default: state_n = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_HUNT;
      remain_q   <= '0;
      crch_q     <= '0;
      wr_stb     <= 1'b0;
      wr_data    <= '0;
      sync_det   <= 1'b0;
      addr_match <= 1'b0;
      evt_pulse  <= 1'b0;
      pkt_ok     <= 1'b0;
      pkt_bad    <= 1'b0;
      pkt_drop   <= 1'b0;
    end else begin
      state_q    <= state_n;
      remain_q   <= remain_n;
      crch_q     <= crch_n;
      wr_stb     <= wr_n;
      wr_data    <= wdata_n;
      sync_det   <= sync_n;
      addr_match <= amatch_n;
      evt_pulse  <= cfg_evt_addr ? amatch_n : sync_n;
      pkt_ok     <= ok_n;
      pkt_bad    <= bad_n;
      pkt_drop   <= drop_n;
    end
  end
endmodule

// File: rtl/prx_checker.sv
module prx_checker (
  input logic clk,
  input logic rst_n,
  input logic bit_valid,
  input logic cfg_addr_en,
  input logic wr_stb,
  input logic sync_det,
  input logic addr_match,
  input logic pkt_ok,
  input logic pkt_bad,
  input logic pkt_drop
);
  // R1
  sync_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_det |-> $past(bit_valid));

  // R2
  no_write_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_det |-> !wr_stb);

  // R3
  write_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(bit_valid));

  // R8
  addr_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |-> cfg_addr_en);

  // R9
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_ok && pkt_bad));

  // R10
  drop_only_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_drop |-> pkt_bad);

  // R2
  verdict_not_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ok || pkt_bad) |-> !wr_stb);
endmodule

bind pkt_rx_filter prx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .cfg_addr_en(cfg_addr_en),
  .wr_stb(wr_stb), .sync_det(sync_det), .addr_match(addr_match),
  .pkt_ok(pkt_ok), .pkt_bad(pkt_bad), .pkt_drop(pkt_drop)
);

// File: tb/tb_pkt_rx_filter.sv
module tb_pkt_rx_filter;
  localparam int SYNC_W = 16;
  localparam logic [15:0] SYNC = 16'h2DD4;
  localparam logic [7:0]  NODE = 8'h5A;

  logic clk = 1'b0;
  logic rst_n;
  logic bit_valid, bit_in;
  logic cfg_len_en, cfg_addr_en, cfg_crc_drop, cfg_evt_addr;
  logic [1:0] cfg_addr_mode;
  logic [7:0] cfg_max_len;
  logic wr_stb, sync_det, addr_match, evt_pulse, pkt_ok, pkt_bad, pkt_drop;
  logic [7:0] wr_data;

  always #5 clk = ~clk;

  pkt_rx_filter #(.SYNC_W(SYNC_W)) dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .cfg_sync(SYNC), .cfg_len_en(cfg_len_en), .cfg_addr_en(cfg_addr_en),
    .cfg_addr_mode(cfg_addr_mode), .cfg_node_addr(NODE), .cfg_max_len(cfg_max_len),
    .cfg_crc_drop(cfg_crc_drop), .cfg_evt_addr(cfg_evt_addr),
    .wr_stb(wr_stb), .wr_data(wr_data), .sync_det(sync_det), .addr_match(addr_match),
    .evt_pulse(evt_pulse), .pkt_ok(pkt_ok), .pkt_bad(pkt_bad), .pkt_drop(pkt_drop)
  );

  int n_chk = 0, n_fail = 0;
  int n_wr, n_sync, n_addr, n_evt, n_ok, n_bad, n_drop;
  logic [7:0] got [0:63];
  logic [7:0] sent [0:63];
  bit done = 0;
  int gap = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        if (n_wr < 64) got[n_wr] = wr_data;
        n_wr++;
      end
      if (sync_det)   n_sync++;
      if (addr_match) n_addr++;
      if (evt_pulse)  n_evt++;
      if (pkt_ok)     n_ok++;
      if (pkt_bad)    n_bad++;
      if (pkt_drop)   n_drop++;
    end
  end

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] tb_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int b = 7; b >= 0; b--) begin
      logic fb = r[15] ^ d[b];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_in    = b;
    if (gap != 0) begin
      @(negedge clk);
      bit_valid = 1'b0;
      bit_in    = ~b;
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_valid = 1'b0;
      bit_in    = 1'b0;
    end
  endtask

  function automatic bit addr_pass(input logic [7:0] a, input logic [1:0] m);
    if (a == NODE) return 1;
    if (m == 2'd1 && a == 8'h00) return 1;
    if (m >= 2'd2 && (a == 8'h00 || a == 8'hFF)) return 1;
    return 0;
  endfunction

  // Send one packet and check the result against the requirements
  task automatic run_pkt(input logic [7:0] len, input logic [7:0] addr,
                         input bit corrupt, input int seed);
    logic [15:0] crc;
    int  plen;
    bit  acc;
    int  exp_wr, exp_ok, exp_bad, exp_drop, exp_addr, exp_evt;
    n_wr = 0; n_sync = 0; n_addr = 0; n_evt = 0; n_ok = 0; n_bad = 0; n_drop = 0;
    plen = cfg_len_en ? int'(len) : int'(cfg_max_len);
    acc  = (!cfg_len_en || len <= cfg_max_len) && (!cfg_addr_en || addr_pass(addr, cfg_addr_mode));
    crc  = 16'hFFFF;
    send_byte(8'hAA); send_byte(8'hAA);
    send_byte(SYNC[15:8]); send_byte(SYNC[7:0]);
    if (cfg_len_en)  begin send_byte(len);  crc = tb_crc(crc, len);  end
    if (cfg_addr_en) begin send_byte(addr); crc = tb_crc(crc, addr); end
    for (int k = 0; k < plen && k < 64; k++) begin
      sent[k] = 8'((seed * 37 + k * 11 + 3) & 8'h7F);
      send_byte(sent[k]);
      crc = tb_crc(crc, sent[k]);
    end
    if (corrupt) crc = crc ^ 16'h0100;
    send_byte(crc[15:8]); send_byte(crc[7:0]);
    idle(4);
    exp_wr   = acc ? plen : 0;
    exp_ok   = (acc && !corrupt) ? 1 : 0;
    exp_bad  = (acc && corrupt) ? 1 : 0;
    exp_drop = (acc && corrupt && cfg_crc_drop) ? 1 : 0;
    exp_addr = (acc && cfg_addr_en) ? 1 : 0;
    exp_evt  = cfg_evt_addr ? exp_addr : 1;
    chk(n_sync == 1, "R1 sync_det count", n_sync, 1);
    chk(n_wr == exp_wr, "R2/R4 write count", n_wr, exp_wr);
    for (int k = 0; k < exp_wr && k < n_wr && k < 64; k++)
      chk(got[k] == sent[k], "R3 payload byte", int'(got[k]), int'(sent[k]));
    chk(n_addr == exp_addr, "R5/R6/R7/R8 addr_match count", n_addr, exp_addr);
    chk(n_ok == exp_ok, "R9 pkt_ok count", n_ok, exp_ok);
    chk(n_bad == exp_bad, "R10 pkt_bad count", n_bad, exp_bad);
    chk(n_drop == exp_drop, "R10 pkt_drop count", n_drop, exp_drop);
    chk(n_evt == exp_evt, "R11 evt_pulse count", n_evt, exp_evt);
  endtask

  initial begin
    rst_n = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
    cfg_len_en = 1'b1; cfg_addr_en = 1'b1; cfg_addr_mode = 2'd0;
    cfg_max_len = 8'd6; cfg_crc_drop = 1'b0; cfg_evt_addr = 1'b0;
    idle(3);
    @(negedge clk);
    chk({wr_stb, sync_det, addr_match, evt_pulse, pkt_ok, pkt_bad, pkt_drop} == 7'b0,
        "R1 reset outputs", 1, 0);
    rst_n = 1'b1;
    idle(2);

    // R5 R6 R7 R8 sweep: every mode against node, 0x00, 0xFF and a foreign value
    for (int le = 0; le < 2; le++) begin
      for (int m = 0; m < 4; m++) begin
        for (int a = 0; a < 4; a++) begin
          logic [7:0] av;
          av = (a == 0) ? NODE : (a == 1) ? 8'h00 : (a == 2) ? 8'hFF : 8'h33;
          cfg_len_en    = le[0];
          cfg_addr_mode = m[1:0];
          cfg_evt_addr  = a[0];
          cfg_max_len   = 8'd4;
          run_pkt(8'd3, av, 1'b0, le * 16 + m * 4 + a);
        end
      end
    end

    // R9 R10: CRC corruption in flag and discard modes, lengths 0 and 5
    cfg_len_en = 1'b1; cfg_addr_mode = 2'd0; cfg_max_len = 8'd6; cfg_evt_addr = 1'b1;
    for (int d = 0; d < 2; d++) begin
      cfg_crc_drop = d[0];
      run_pkt(8'd5, NODE, 1'b1, 40 + d);
      run_pkt(8'd0, NODE, 1'b1, 42 + d);
      run_pkt(8'd5, NODE, 1'b0, 44 + d);
    end

    // R4: length above the limit, at the limit, fixed length without length byte
    cfg_crc_drop = 1'b0; cfg_evt_addr = 1'b0;
    run_pkt(8'd7, NODE, 1'b0, 50);
    run_pkt(8'd6, NODE, 1'b0, 51);
    cfg_len_en = 1'b0; cfg_max_len = 8'd2;
    run_pkt(8'd0, NODE, 1'b0, 52);

    // R2 R3: no header bytes at all, and gaps in bit_valid
    cfg_addr_en = 1'b0; cfg_max_len = 8'd5;
    run_pkt(8'd0, 8'h00, 1'b0, 53);
    gap = 1;
    cfg_len_en = 1'b1; cfg_addr_en = 1'b1; cfg_addr_mode = 2'd2;
    run_pkt(8'd4, 8'hFF, 1'b0, 54);
    run_pkt(8'd4, 8'h12, 1'b0, 55);
    run_pkt(8'd2, NODE, 1'b1, 56);
    gap = 0;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule